// File: doc/BRIEF.md
# Select-Before-Sum Carry Select Adder

This block adds two unsigned binary operands and a carry-in. It gives an N-bit sum and a carry-out. The operand width is cut into groups whose widths grow toward the most significant end, in the usual square-root fashion.

Each group works out two candidate carry words ahead of time:

- one assumes a group carry-in of 0;
- the other assumes a group carry-in of 1.

The real carry from the group below picks one candidate word. Only after that pick are the group's sum bits formed, as the half-sum of each bit XOR the picked carry into that bit. The top bit of the picked word is the group's carry-out, and it drives the pick in the next group up.

The combinational adder sits behind a thin registered stage so that it can be timed as one pipeline step. The result therefore appears one clock after the operands are presented.

Top module: `csel_adder`

## Requirements
- R1: One rising clock edge after `op_a`, `op_b` and `carry_in` are sampled with `rst` low, `{carry_q, sum_q}` equals the (WIDTH+1)-bit value `op_a + op_b + carry_in`.
- R2: A rising edge with `rst` high sets `sum_q` to all zeros and `carry_q` to 0, whatever the operands are.
- R3: `carry_q` is 1 exactly when `op_a + op_b + carry_in` is 2^WIDTH or more, for example 0x8000 + 0x8000 at WIDTH = 16.
- R4: Group widths are 2, 2, 3, 4, 5, 6 and so on from the least significant bit, and the last group is cut to the bits that remain. At WIDTH = 16 the groups are bits 1:0, 3:2, 6:4, 10:7 and 15:11. A carry made at the top bit of any group reaches the next group's lowest sum bit correctly.
- R5: Inside every group, the candidate carry word for carry-in 0 never has a 1 where the candidate word for carry-in 1 has a 0.
- R6: A carry entering at bit 0 travels through every group. At WIDTH = 16, 0xFFFF + 0x0000 + 1 gives sum 0x0000 and carry 1, and 0x5555 + 0xAAAA + 1 gives the same result.
- R7: The adder is correct at WIDTH = 8, where the groups are 2, 2, 3 and a final group of 1 bit, for every operand pair and carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | WIDTH | Registered sum |
| carry_q | output | 1 | Registered carry-out |

## Verification
The hardest case to reach from the ports is a carry that has to cross every group boundary. In that case each group's pick depends on the pick made below it, and random operands seldom set up the long chain of propagate bits this needs. The stimulus builds it on purpose: all-ones plus a carry-in, alternating-bit patterns that propagate at every position, and operand pairs that generate a carry at the top bit of each group. An 8-bit instance is swept over every operand pair and carry-in, which covers every pick pattern, including the truncated final group.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // width of the first two groups; later groups grow by one bit each
    localparam int FIRST_W = 2;

    function automatic int nominal_w(input int k);
        return (k < 2) ? FIRST_W : FIRST_W + k - 1;
    endfunction

    function automatic int group_count(input int width);
        int used;
        int n;
        used = 0;
        n = 0;
        while (used < width) begin
            used = used + nominal_w(n);
            n = n + 1;
        end
        return n;
    endfunction

    function automatic int group_lsb(input int k);
        int lsb;
        lsb = 0;
        for (int i = 0; i < k; i++) lsb = lsb + nominal_w(i);
        return lsb;
    endfunction

    // last group is truncated to the bits that remain
    function automatic int group_width(input int width, input int k);
        int rest;
        rest = width - group_lsb(k);
        return (nominal_w(k) < rest) ? nominal_w(k) : rest;
    endfunction

endpackage

// File: rtl/csel_carry_gen.sv
module csel_carry_gen #(
    parameter int W = 2
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    output logic [W:0]   c_lo,
    output logic [W:0]   c_hi
);
    // With the carry-in fixed, bit 0 collapses: c_lo[1] = gen, c_hi[1] = gen | prop.
    always_comb begin
        c_lo[0] = 1'b0;
        c_hi[0] = 1'b1;
        c_lo[1] = gen[0];
        c_hi[1] = gen[0] | prop[0];
        for (int i = 1; i < W; i++) begin
            c_lo[i+1] = gen[i] | (prop[i] & c_lo[i]);
            c_hi[i+1] = gen[i] | (prop[i] & c_hi[i]);
        end
    end

    always_comb begin
        if (!$isunknown({gen, prop})) begin
            // R5
            lo_within_hi_chk: assert ((c_lo & ~c_hi) == '0);
        end
    end

endmodule

// File: rtl/csel_group.sv
module csel_group #(
    parameter int W = 2
) (
    input  logic [W-1:0] a_s,
    input  logic [W-1:0] b_s,
    input  logic         c_in,
    output logic [W-1:0] s,
    output logic         c_out
);
    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W:0]   c_lo;
    logic [W:0]   c_hi;
    logic [W:0]   c_sel;

    assign gen  = a_s & b_s;
    assign prop = a_s ^ b_s;

    csel_carry_gen #(.W(W)) u_cgen (
        .gen  (gen),
        .prop (prop),
        .c_lo (c_lo),
        .c_hi (c_hi)
    );

    // carry word is chosen first, the sum is formed afterwards
    assign c_sel = c_in ? c_hi : c_lo;
    assign s     = prop ^ c_sel[W-1:0];
    assign c_out = c_sel[W];

    always_comb begin
        if (!$isunknown({a_s, b_s, c_in})) begin
            // R4
            slice_sum_chk: assert ({c_out, s} ==
                ({1'b0, a_s} + {1'b0, b_s} + {{W{1'b0}}, c_in}));
        end
    end

endmodule

// File: rtl/csel_core.sv
module csel_core #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NG = csel_pkg::group_count(WIDTH);

    logic [NG:0] chain;

    assign chain[0] = cin;

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        localparam int LSB = csel_pkg::group_lsb(gi);
        localparam int GW  = csel_pkg::group_width(WIDTH, gi);

        csel_group #(.W(GW)) u_grp (
            .a_s   (a[LSB +: GW]),
            .b_s   (b[LSB +: GW]),
            .c_in  (chain[gi]),
            .s     (sum[LSB +: GW]),
            .c_out (chain[gi+1])
        );
    end

    assign cout = chain[NG];

endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_q,
    output logic             carry_q
);
    typedef struct packed {
        logic             carry;
        logic [WIDTH-1:0] bits;
    } result_t;

    result_t comb_r;
    result_t reg_r;

    csel_core #(.WIDTH(WIDTH)) u_core (
        .a    (op_a),
        .b    (op_b),
        .cin  (carry_in),
        .sum  (comb_r.bits),
        .cout (comb_r.carry)
    );

    always_ff @(posedge clk) begin
        if (rst) reg_r <= '0;
        else     reg_r <= comb_r;
    end

    assign sum_q   = reg_r.bits;
    assign carry_q = reg_r.carry;

    // behavioural reference used only by the checks below
    logic [WIDTH:0] ref_w;
    assign ref_w = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

    // R1
    result_match_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ({carry_q, sum_q} == $past(ref_w)));

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sum_q == '0 && !carry_q));

    // R3
    carry_out_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (carry_q == $past(ref_w[WIDTH])));

endmodule

// File: tb/csel_adder_test.sv
`timescale 1ns/1ps
module csel_adder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [15:0] a16 = '0, b16 = '0;
    logic        c16 = 1'b0;
    logic [15:0] s16;
    logic        co16;

    logic [7:0]  a8 = '0, b8 = '0;
    logic        c8 = 1'b0;
    logic [7:0]  s8;
    logic        co8;

    csel_adder #(.WIDTH(16)) uut (
        .clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .carry_in(c16),
        .sum_q(s16), .carry_q(co16)
    );

    csel_adder #(.WIDTH(8)) uut8 (
        .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .carry_in(c8),
        .sum_q(s8), .carry_q(co8)
    );

    typedef struct { logic [16:0] exp; string tag; } item16_t;
    typedef struct { logic [8:0]  exp; string tag; } item8_t;

    item16_t q16[$];
    item8_t  q8[$];

    int checks = 0;
    int bad    = 0;
    int cycles = 0;
    bit done   = 1'b0;

    task automatic check17(input string tag, input logic [16:0] got, input logic [16:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive16(input logic [15:0] a, input logic [15:0] b, input logic c, input string tag);
        item16_t it;
        @(negedge clk);
        a16 = a; b16 = b; c16 = c;
        it.exp = {1'b0, a} + {1'b0, b} + {16'b0, c};
        it.tag = tag;
        q16.push_back(it);
    endtask

    task automatic drive8(input logic [7:0] a, input logic [7:0] b, input logic c);
        item8_t it;
        @(negedge clk);
        a8 = a; b8 = b; c8 = c;
        it.exp = {1'b0, a} + {1'b0, b} + {8'b0, c};
        it.tag = "R7";
        q8.push_back(it);
    endtask

    // monitors: outputs settle after the edge that captured the inputs
    initial forever begin
        @(posedge clk); #1;
        if (q16.size() > 0) begin
            item16_t it;
            it = q16.pop_front();
            check17(it.tag, {co16, s16}, it.exp);
        end
        if (q8.size() > 0) begin
            item8_t it;
            it = q8.pop_front();
            check17(it.tag, {8'b0, co8, s8}, {8'b0, it.exp});
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            checks++;
            bad++;
            $display("FAIL R1: watchdog expired, got %0d cycles expected under 190000", cycles);
            finish_run();
        end
    end

    task automatic run16();
        // R6: long carry chains across every group
        drive16(16'hFFFF, 16'h0000, 1'b1, "R6");
        drive16(16'h5555, 16'hAAAA, 1'b1, "R6");
        drive16(16'hFFFF, 16'hFFFF, 1'b1, "R6");
        drive16(16'h0000, 16'h0000, 1'b0, "R1");
        drive16(16'hAAAA, 16'hAAAA, 1'b0, "R1");
        drive16(16'h5555, 16'h5555, 1'b1, "R1");
        // R3: carry-out boundaries
        drive16(16'h8000, 16'h8000, 1'b0, "R3");
        drive16(16'hFFFF, 16'h0000, 1'b0, "R3");
        drive16(16'h7FFF, 16'h8000, 1'b1, "R3");
        // R4: carry generated at the top bit of each group (bits 1,3,6,10)
        for (int k = 0; k < 4; k++) begin
            int t;
            t = (k == 0) ? 1 : (k == 1) ? 3 : (k == 2) ? 6 : 10;
            drive16(16'(1) << t, 16'(1) << t, 1'b0, "R4");
            drive16((16'(1) << t) | 16'h0001, 16'hFFFF >> (15 - t), 1'b1, "R4");
        end
        // R1: random operands
        for (int n = 0; n < 3000; n++)
            drive16(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    endtask

    task automatic run8();
        // R7: every operand pair and carry-in at WIDTH = 8
        for (int x = 0; x < 512; x++)
            for (int y = 0; y < 256; y++)
                drive8(8'(x), 8'(y), x[8]);
    endtask

    initial begin
        // R2: reset wins over nonzero operands
        a16 = 16'hFFFF; b16 = 16'hFFFF; c16 = 1'b1;
        a8 = 8'hFF; b8 = 8'hFF; c8 = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check17("R2", {co16, s16}, 17'h0);
        check17("R2", {8'b0, co8, s8}, 17'h0);
        @(negedge clk);
        rst = 1'b0;
        fork
            run16();
            run8();
        join
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (q16.size() != 0 || q8.size() != 0) begin
            bad++;
            $display("FAIL R1: pending results got %0d expected 0", q16.size() + q8.size());
        end
        // R2: reset mid-run clears results
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check17("R2", {co16, s16}, 17'h0);
        done = 1'b1;
        finish_run();
    end

endmodule